// File: doc/BRIEF.md
# Real-Time Clock Update Handshake Controller

This block sits between software control bits and the counting chains of a BCD real-time clock. The clock has two chains: a time chain (hours, minutes, seconds) and a calendar chain (century, year, month, date, weekday) that sits downstream of it. The controller takes the 1 Hz tick and produces one count enable per chain. When software asks to change a group of fields, the controller freezes the matching chains and raises an acknowledge flag. It passes field-load strobes to the chains only while they are frozen and only after software has cleared that flag.

A time request stops both chains, because the calendar only advances on carries out of the time chain. A calendar-only request stops the calendar chain and lets the time chain run. The freeze always starts just after a tick boundary, so no carry is ever split between two chains. The block also keeps a per-second event flag. After a release, it holds off the next request until a tick has been seen, so two updates are always at least one second apart.

Top module: `rtc_upd_ctrl`

## Requirements
- R1: After reset the acknowledge flag, the second flag and both load outputs are 0. With no update in progress, each chain enable equals `tick_1hz` in the same cycle.
- R2: The second flag sets in the cycle after `tick_1hz` is high. `sec_clr` clears it in the cycle after its pulse. When both occur together, the flag sets. Otherwise it holds its value.
- R3: An accepted request freezes its chains on the first tick that follows acceptance. That tick still reaches the chains. From the next cycle the acknowledge flag is 1 and the chains are frozen.
- R4: A time request (`upd_time`=1) freezes both the time and calendar enables. If both request bits are high when the request is accepted, the time behaviour applies.
- R5: A calendar-only request (`upd_cal`=1, `upd_time`=0) freezes only the calendar enable. `time_cnt_en` keeps following `tick_1hz`.
- R6: A load strobe reaches its `*_load_go` output only while its chain is frozen and the acknowledge flag is 0. In every other case the strobe is ignored and the output stays 0.
- R7: `ack_clr` clears the acknowledge flag in the cycle after its pulse. Without that pulse the flag holds its value.
- R8: Once both request bits are 0 while frozen, counting resumes from the next cycle, and both enables follow `tick_1hz` again.
- R9: After a release, a new request is not accepted until a tick has occurred after that release. A request held off in this way raises no acknowledge on that tick.
- R10: If the request bits drop before the freezing tick arrives, the request is cancelled. No acknowledge is raised and no chain is frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| upd_time | input | 1 | Level request to update the time fields |
| upd_cal | input | 1 | Level request to update the calendar fields |
| ack_clr | input | 1 | Pulse that clears the acknowledge flag |
| sec_clr | input | 1 | Pulse that clears the second flag |
| time_load | input | 1 | Strobe to load new time field values |
| cal_load | input | 1 | Strobe to load new calendar field values |
| time_cnt_en | output | 1 | Count enable for the time chain |
| cal_cnt_en | output | 1 | Count enable for the calendar chain |
| ack_flag | output | 1 | Chains frozen; acknowledge pending |
| sec_flag | output | 1 | Per-second event flag |
| time_load_go | output | 1 | Time load strobe let through to the chain |
| cal_load_go | output | 1 | Calendar load strobe let through to the chain |

## Verification
The hardest case to reach is the re-arm hold-off. It needs a full freeze and release, followed at once by a new request before any tick. In that state an accepted request and a held-off request look the same on the enables, because the tick that would freeze the chains is itself still passed through. The bench therefore releases a time update and raises a calendar request in the next cycle. It sends one tick and checks that no acknowledge follows. A second tick must then freeze only the calendar chain.

// File: rtl/rtc_upd_pkg.sv
// Shared types for the clock update handshake controller.
// Assumes exactly two chains: index 0 = time, index 1 = calendar.
package rtc_upd_pkg;
    localparam int N_CHAIN   = 2;
    localparam int CH_TIME   = 0;
    localparam int CH_CAL    = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_FROZEN = 2'd2
    } upd_state_e;

    typedef enum logic {
        MODE_CAL  = 1'b0,
        MODE_TIME = 1'b1
    } upd_mode_e;
endpackage

// File: rtl/upd_flag.sv
// Sticky status flag with a set pulse and a clear pulse.
// Assumes both pulses are synchronous to clk; set takes priority.
module upd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold, set or clear the flag; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/upd_fsm.sv
// Request sequencer: accepts update requests, waits for a tick boundary,
// freezes the chains chosen by the latched mode and releases them when
// all request bits drop. A re-arm bit blocks new requests after a release
// until one tick has been seen. Assumes tick_i is a one-cycle pulse.
module upd_fsm
    import rtc_upd_pkg::*;
#(
    parameter int NCH = N_CHAIN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           req_time_i,
    input  logic           req_cal_i,
    output logic [NCH-1:0] frozen_o,
    output logic           ack_set_o
);
    upd_state_e state_q, state_d;
    upd_mode_e  mode_q,  mode_d;
    logic       armed_q, armed_d;
    logic       req_any;

    // Either request bit counts as a pending update.
    always_comb req_any = req_time_i | req_cal_i;

    // Next-state, mode and re-arm decisions.
    always_comb begin
        state_d   = state_q;
        mode_d    = mode_q;
        armed_d   = armed_q | tick_i;
        ack_set_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_any && armed_q) begin
                    state_d = ST_PEND;
                    mode_d  = req_time_i ? MODE_TIME : MODE_CAL;
                end
            end
            ST_PEND: begin
                if (!req_any)
                    state_d = ST_IDLE;
                else if (tick_i) begin
                    state_d   = ST_FROZEN;
                    ack_set_o = 1'b1;
                end
            end
            ST_FROZEN: begin
                if (!req_any) begin
                    state_d = ST_IDLE;
                    armed_d = 1'b0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, mode and re-arm registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_CAL;
            armed_q <= 1'b1;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            armed_q <= armed_d;
        end
    end

    // Per-chain freeze decode: calendar freezes in any mode, time only in time mode.
    for (genvar g = 0; g < NCH; g++) begin : g_frz
        if (g == CH_TIME) begin : g_time
            always_comb frozen_o[g] = (state_q == ST_FROZEN) && (mode_q == MODE_TIME);
        end else begin : g_other
            always_comb frozen_o[g] = (state_q == ST_FROZEN);
        end
    end

    assert_freeze_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && req_any && tick_i) |=> (state_q == ST_FROZEN));
    assert_holdoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !armed_q) |=> (state_q != ST_PEND));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN && !req_any) |=> (frozen_o == '0));
    assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && !req_any) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/chain_gate.sv
// Per-chain gating of the 1 Hz count enable and of the field-load strobes.
// Assumes frozen_i comes from the sequencer and ack_i from the acknowledge flag.
module chain_gate #(
    parameter int NCH = 2
) (
    input  logic           tick_i,
    input  logic           ack_i,
    input  logic [NCH-1:0] frozen_i,
    input  logic [NCH-1:0] load_i,
    output logic [NCH-1:0] cnt_en_o,
    output logic [NCH-1:0] load_go_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Pass the tick unless this chain is frozen.
        always_comb cnt_en_o[g] = tick_i & ~frozen_i[g];
        // Pass a load strobe only into a frozen chain once ack is cleared.
        always_comb load_go_o[g] = load_i[g] & frozen_i[g] & ~ack_i;
    end
endmodule

// File: rtl/rtc_upd_ctrl.sv
// Top of the clock update handshake controller. Ties the sequencer, the
// acknowledge and second flags and the per-chain gates together.
// Assumes all inputs are synchronous to clk and tick_1hz is one cycle wide.
module rtc_upd_ctrl
    import rtc_upd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1hz,
    input  logic upd_time,
    input  logic upd_cal,
    input  logic ack_clr,
    input  logic sec_clr,
    input  logic time_load,
    input  logic cal_load,
    output logic time_cnt_en,
    output logic cal_cnt_en,
    output logic ack_flag,
    output logic sec_flag,
    output logic time_load_go,
    output logic cal_load_go
);
    logic [N_CHAIN-1:0] frozen;
    logic [N_CHAIN-1:0] load_vec;
    logic [N_CHAIN-1:0] en_vec;
    logic [N_CHAIN-1:0] go_vec;
    logic               ack_set;

    upd_fsm #(.NCH(N_CHAIN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_1hz),
        .req_time_i (upd_time),
        .req_cal_i  (upd_cal),
        .frozen_o   (frozen),
        .ack_set_o  (ack_set)
    );

    upd_flag u_ack (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ack_set),
        .clr_i  (ack_clr),
        .flag_o (ack_flag)
    );

    upd_flag u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (tick_1hz),
        .clr_i  (sec_clr),
        .flag_o (sec_flag)
    );

    // Pack the per-chain load strobes by chain index.
    always_comb begin
        load_vec          = '0;
        load_vec[CH_TIME] = time_load;
        load_vec[CH_CAL]  = cal_load;
    end

    chain_gate #(.NCH(N_CHAIN)) u_gate (
        .tick_i    (tick_1hz),
        .ack_i     (ack_flag),
        .frozen_i  (frozen),
        .load_i    (load_vec),
        .cnt_en_o  (en_vec),
        .load_go_o (go_vec)
    );

    // Unpack gated enables and load strobes onto the ports.
    always_comb begin
        time_cnt_en  = en_vec[CH_TIME];
        cal_cnt_en   = en_vec[CH_CAL];
        time_load_go = go_vec[CH_TIME];
        cal_load_go  = go_vec[CH_CAL];
    end

    assert_time_stops_cal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen[CH_TIME] && tick_1hz) |-> !cal_cnt_en);
    assert_load_only_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (time_load_go || cal_load_go) |-> (!ack_flag && frozen != '0));
    assert_ack_means_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_flag) |-> frozen[CH_CAL]);
endmodule

// File: tb/sim_rtc_upd_ctrl.sv
`timescale 1ns/1ps
module sim_rtc_upd_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1hz = 0, upd_time = 0, upd_cal = 0, ack_clr = 0, sec_clr = 0;
    logic time_load = 0, cal_load = 0;
    logic time_cnt_en, cal_cnt_en, ack_flag, sec_flag, time_load_go, cal_load_go;
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;

    always #4 clk = ~clk;

    rtc_upd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .upd_time(upd_time),
        .upd_cal(upd_cal), .ack_clr(ack_clr), .sec_clr(sec_clr),
        .time_load(time_load), .cal_load(cal_load),
        .time_cnt_en(time_cnt_en), .cal_cnt_en(cal_cnt_en),
        .ack_flag(ack_flag), .sec_flag(sec_flag),
        .time_load_go(time_load_go), .cal_load_go(cal_load_go)
    );

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge, then settle 1 ns before sampling.
    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 ack after reset", ack_flag, 1'b0);
        chk("R1 sec after reset", sec_flag, 1'b0);
        time_load = 1; cal_load = 1; #1;
        chk("R1 time_load_go idle", time_load_go, 1'b0);
        chk("R1 cal_load_go idle", cal_load_go, 1'b0);
        time_load = 0; cal_load = 0;
        tick_1hz = 1; #1;
        chk("R1 time_en follows tick", time_cnt_en, 1'b1);
        chk("R1 cal_en follows tick", cal_cnt_en, 1'b1);
        cyc(); tick_1hz = 0; #1;
        chk("R1 time_en low without tick", time_cnt_en, 1'b0);
    endtask

    task automatic t_sec_flag();
        chk("R2 sec set after tick", sec_flag, 1'b1);
        sec_clr = 1; cyc(); sec_clr = 0;
        chk("R2 sec cleared", sec_flag, 1'b0);
        cyc();
        chk("R2 sec holds clear", sec_flag, 1'b0);
        tick_1hz = 1; sec_clr = 1; cyc(); tick_1hz = 0; sec_clr = 0;
        chk("R2 set wins over clear", sec_flag, 1'b1);
        sec_clr = 1; cyc(); sec_clr = 0;
    endtask

    task automatic t_time_update();
        upd_time = 1; cyc(); cyc();
        chk("R3 no ack before tick", ack_flag, 1'b0);
        tick_1hz = 1; #1;
        chk("R3 boundary tick reaches time", time_cnt_en, 1'b1);
        chk("R3 boundary tick reaches cal", cal_cnt_en, 1'b1);
        cyc(); tick_1hz = 0; #1;
        chk("R3 ack set after tick", ack_flag, 1'b1);
        tick_1hz = 1; #1;
        chk("R4 time frozen", time_cnt_en, 1'b0);
        chk("R4 cal frozen", cal_cnt_en, 1'b0);
        cyc(); tick_1hz = 0; #1;
        cyc();
        chk("R7 ack holds without clear", ack_flag, 1'b1);
        time_load = 1; #1;
        chk("R6 load ignored while ack set", time_load_go, 1'b0);
        time_load = 0; ack_clr = 1; cyc(); ack_clr = 0;
        chk("R7 ack cleared", ack_flag, 1'b0);
        time_load = 1; cal_load = 1; #1;
        chk("R6 time load passes", time_load_go, 1'b1);
        chk("R6 cal load passes", cal_load_go, 1'b1);
        cyc(); time_load = 0; cal_load = 0;
    endtask

    task automatic t_release_holdoff();
        upd_time = 0; cyc();
        upd_cal = 1; cyc(); cyc();
        tick_1hz = 1; #1;
        chk("R8 time runs after release", time_cnt_en, 1'b1);
        chk("R8 cal runs after release", cal_cnt_en, 1'b1);
        cyc(); tick_1hz = 0; #1;
        chk("R9 held-off request no ack", ack_flag, 1'b0);
        cyc(); cyc();
        tick_1hz = 1; cyc(); tick_1hz = 0; #1;
        chk("R9 request accepted after rearm", ack_flag, 1'b1);
        tick_1hz = 1; #1;
        chk("R5 time keeps counting", time_cnt_en, 1'b1);
        chk("R5 cal frozen", cal_cnt_en, 1'b0);
        cyc(); tick_1hz = 0;
        ack_clr = 1; cyc(); ack_clr = 0;
        time_load = 1; cal_load = 1; #1;
        chk("R6 time load ignored in cal mode", time_load_go, 1'b0);
        chk("R6 cal load passes in cal mode", cal_load_go, 1'b1);
        cyc(); time_load = 0; cal_load = 0;
        upd_cal = 0; cyc();
        tick_1hz = 1; cyc(); tick_1hz = 0; cyc();
        time_load = 1; cal_load = 1; #1;
        chk("R6 cal load ignored after release", cal_load_go, 1'b0);
        cyc(); time_load = 0; cal_load = 0;
    endtask

    task automatic t_cancel();
        upd_time = 1; cyc(); cyc();
        upd_time = 0; cyc();
        tick_1hz = 1; #1;
        chk("R10 tick passes after cancel", cal_cnt_en, 1'b1);
        cyc(); tick_1hz = 0; #1;
        chk("R10 no ack after cancel", ack_flag, 1'b0);
        tick_1hz = 1; #1;
        chk("R10 time not frozen", time_cnt_en, 1'b1);
        cyc(); tick_1hz = 0;
    endtask

    task automatic t_both_requests();
        upd_time = 1; upd_cal = 1; cyc(); cyc();
        tick_1hz = 1; cyc(); tick_1hz = 0; #1;
        chk("R4 ack with both requests", ack_flag, 1'b1);
        tick_1hz = 1; #1;
        chk("R4 time wins: time frozen", time_cnt_en, 1'b0);
        chk("R4 time wins: cal frozen", cal_cnt_en, 1'b0);
        cyc(); tick_1hz = 0;
        upd_time = 0; upd_cal = 0; ack_clr = 1; cyc(); ack_clr = 0;
        tick_1hz = 1; #1;
        chk("R8 both chains resume", time_cnt_en & cal_cnt_en, 1'b1);
        cyc(); tick_1hz = 0;
    endtask

    initial begin
        cyc(); cyc();
        rst_n = 1;
        cyc();
        t_reset();
        t_sec_flag();
        t_time_update();
        t_release_holdoff();
        t_cancel();
        t_both_requests();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule